// File: doc/BRIEF.md
# Time Reference Selector with Holdover

This block chooses which of several time reference inputs drives the card's downstream clock loop. Each input carries a health flag; an input is eligible only after its flag has stayed high for a programmable qualification time. Among eligible inputs the lowest index wins. Index 0 has the highest priority. The block watches the loop's lock indication and moves between four states. It reports each decision as a one-cycle event strobe with its own payload: reference switches with source and destination, relock with the time it took, loss of lock with the failed reference, holdover entry and exit with duration, and time jumps.

A local time counter is compared with a reference timestamp on each sample. When the offset between them moves by more than a threshold in one sample, a time jump is flagged. A jump while locked forces a re-acquire. The gating output follows the state. Strict gating is allowed only while locked. Holdover relaxes gating, and acquisition or free-run falls back to measurement-only operation with an alarm.

States: FREE (no reference), ACQUIRE (reference chosen, waiting for lock), LOCKED, HOLDOVER. Transitions: FREE→ACQUIRE on an eligible input; ACQUIRE→LOCKED on lock; ACQUIRE→ACQUIRE on failover or preemption; ACQUIRE→FREE when the selected input fails with no alternative; LOCKED→ACQUIRE on failover, preemption or time jump; LOCKED→HOLDOVER on failure with no usable alternative; HOLDOVER→ACQUIRE when an input becomes eligible; HOLDOVER→FREE on holdover timeout.

Top module: `tref_sel`

## Requirements
- R1: The selected reference is the lowest-index eligible input. A lower-index input becoming eligible preempts the current choice in ACQUIRE or LOCKED, subject to R3.
- R2: An input is eligible only after `ref_ok` has been high for `qual_cycles` consecutive clock edges; a low cycle restarts the count; `qual_cycles`=0 means eligible at once.
- R3: After any switch, no further switch occurs until `lockout_cycles` edges have passed; the earliest next switch is on edge `lockout_cycles`+1 after the switching edge.
- R4: From ACQUIRE, lock and a healthy selected input give LOCKED with `ev_relock` and `ev_relock_cyc` equal to the number of edges spent in ACQUIRE without lock.
- R5: In LOCKED, loss of lock or loss of health of the selected input raises `ev_lol` with `ev_lol_ref` set to the selected index.
- R6: On such a failure with no other eligible input (or with lockout active) the state becomes HOLDOVER and `ev_ho_enter` pulses together with `ev_lol`.
- R7: In HOLDOVER, any eligible input (lockout clear) is selected with `ev_switch`, and in the same cycle `ev_ho_exit` reports the edges spent in holdover in `ev_ho_cyc`.
- R8: Holdover lasting `holdover_max` edges after entry moves to FREE on the next edge with `ev_ho_exit` and `ev_ho_cyc`=`holdover_max`.
- R9: On a sample (`ts_vld`) following an earlier sample, `ev_jump` pulses after that edge if |(local−ref) − previous (local−ref)| > `jump_thresh`; the first sample after reset or a switch never flags.
- R10: A jump seen while LOCKED moves to ACQUIRE (measurement-only) without a switch or loss-of-lock event, and a relock follows when lock holds.
- R11: `mode` encodes FREE=0, ACQUIRE=1, LOCKED=2, HOLDOVER=3; `gate` encodes strict=0 (LOCKED), relaxed=1 (HOLDOVER), measurement-only=2 (FREE, ACQUIRE); `alarm` is high in FREE and HOLDOVER. After reset: FREE, `ref_sel`=0, no events.
- R12: Every switch pulses `ev_switch` with `ev_from` the previous and `ev_to` the new selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ok | input | N_REF | Per-input health flags |
| pll_lock | input | 1 | Downstream loop lock indication |
| ts_vld | input | 1 | Time sample valid |
| local_time | input | TIME_W | Local time counter |
| ref_time | input | TIME_W | Reference timestamp |
| jump_thresh | input | CNT_W | Time jump threshold |
| qual_cycles | input | CNT_W | Qualification time |
| lockout_cycles | input | CNT_W | Post-switch lockout |
| holdover_max | input | CNT_W | Holdover limit before free-run |
| ref_sel | output | IDX_W | Mux select |
| mode | output | 2 | State code |
| gate | output | 2 | Gating mode |
| alarm | output | 1 | Degraded-reference alarm |
| ev_switch | output | 1 | Switch event |
| ev_from | output | IDX_W | Previous reference |
| ev_to | output | IDX_W | New reference |
| ev_relock | output | 1 | Lock regained event |
| ev_relock_cyc | output | CNT_W | Edges taken to lock |
| ev_lol | output | 1 | Loss-of-lock event |
| ev_lol_ref | output | IDX_W | Reference that failed |
| ev_ho_enter | output | 1 | Holdover entry event |
| ev_ho_exit | output | 1 | Holdover exit event |
| ev_ho_cyc | output | CNT_W | Holdover duration |
| ev_jump | output | 1 | Time jump event |

## Verification
Holdover exit and a reference switch share one edge. The bench provokes this by dropping the only locked input, waiting three edges in holdover, then raising a different input. It then expects `ev_switch` (0 to 2) and `ev_ho_exit` with duration 3 on the same sampled cycle. Loss of lock coincides with either a failover switch or holdover entry. Both pairings are driven and each strobe is judged on the same sample. Sweeps cover all sixteen health patterns, several qualification lengths and jump deltas either side of the threshold.

// File: rtl/tref_pkg.sv
package tref_pkg;
    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_ACQ   = 2'd1,
        ST_LOCK  = 2'd2,
        ST_HOLD  = 2'd3
    } tref_state_t;

    localparam logic [1:0] GATE_STRICT  = 2'd0;
    localparam logic [1:0] GATE_RELAXED = 2'd1;
    localparam logic [1:0] GATE_MEASURE = 2'd2;
endpackage

// File: rtl/tref_qual.sv
module tref_qual #(
    parameter int N_REF = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REF-1:0] ok,
    input  logic [CNT_W-1:0] qual_cycles,
    output logic [N_REF-1:0] qualified
);
    for (genvar i = 0; i < N_REF; i++) begin : g_in
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (!rst_n || !ok[i]) begin
                cnt_q <= '0;
            end else if (cnt_q < qual_cycles) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end

        assign qualified[i] = ok[i] && (cnt_q >= qual_cycles);

        // R2: a nonzero qualification never grants eligibility on a fresh rise of health
        assert_qual_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ((qual_cycles != '0) && $rose(qualified[i])) |-> $past(ok[i]));
    end
endmodule

// File: rtl/tref_prio.sv
module tref_prio #(
    parameter int N_REF = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_REF-1:0] req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_REF - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tref_jump.sv
module tref_jump #(
    parameter int TIME_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              sample_vld,
    input  logic [TIME_W-1:0] local_time,
    input  logic [TIME_W-1:0] ref_time,
    input  logic [CNT_W-1:0]  thresh,
    output logic              jump
);
    logic [TIME_W-1:0] diff_now;
    logic [TIME_W-1:0] diff_prev_q;
    logic [TIME_W-1:0] delta;
    logic [TIME_W-1:0] delta_abs;
    logic              have_prev_q;
    logic              jump_q;

    assign diff_now  = local_time - ref_time;
    assign delta     = diff_now - diff_prev_q;
    assign delta_abs = delta[TIME_W-1] ? (~delta + 1'b1) : delta;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diff_prev_q <= '0;
            have_prev_q <= 1'b0;
            jump_q      <= 1'b0;
        end else begin
            jump_q <= 1'b0;
            if (clr) begin
                have_prev_q <= 1'b0;
            end else if (sample_vld) begin
                diff_prev_q <= diff_now;
                have_prev_q <= 1'b1;
                jump_q      <= have_prev_q && (delta_abs > TIME_W'(thresh));
            end
        end
    end

    assign jump = jump_q;

    // R9: a jump strobe only ever follows a sample edge
    assert_jump_from_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
        jump_q |-> $past(sample_vld));
endmodule

// File: rtl/tref_sel.sv
module tref_sel
    import tref_pkg::*;
#(
    parameter int N_REF  = 4,
    parameter int TIME_W = 32,
    parameter int CNT_W  = 16,
    localparam int IDX_W = (N_REF > 1) ? $clog2(N_REF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_REF-1:0]  ref_ok,
    input  logic              pll_lock,
    input  logic              ts_vld,
    input  logic [TIME_W-1:0] local_time,
    input  logic [TIME_W-1:0] ref_time,
    input  logic [CNT_W-1:0]  jump_thresh,
    input  logic [CNT_W-1:0]  qual_cycles,
    input  logic [CNT_W-1:0]  lockout_cycles,
    input  logic [CNT_W-1:0]  holdover_max,
    output logic [IDX_W-1:0]  ref_sel,
    output logic [1:0]        mode,
    output logic [1:0]        gate,
    output logic              alarm,
    output logic              ev_switch,
    output logic [IDX_W-1:0]  ev_from,
    output logic [IDX_W-1:0]  ev_to,
    output logic              ev_relock,
    output logic [CNT_W-1:0]  ev_relock_cyc,
    output logic              ev_lol,
    output logic [IDX_W-1:0]  ev_lol_ref,
    output logic              ev_ho_enter,
    output logic              ev_ho_exit,
    output logic [CNT_W-1:0]  ev_ho_cyc,
    output logic              ev_jump
);
    tref_state_t       state_q, nxt_state;
    logic [IDX_W-1:0]  ref_sel_q, sw_to;
    logic [CNT_W-1:0]  lockout_q, acq_cnt_q, ho_cnt_q;
    logic [N_REF-1:0]  qualified, sel_mask;
    logic              best_found, alt_found, jump;
    logic [IDX_W-1:0]  best_idx, alt_idx;
    logic              ok_sel, can_sw;
    logic              do_switch, do_relock, do_lol, do_ho_enter, do_ho_exit, do_reacq;

    tref_qual #(.N_REF(N_REF), .CNT_W(CNT_W)) u_qual (
        .clk(clk), .rst_n(rst_n), .ok(ref_ok),
        .qual_cycles(qual_cycles), .qualified(qualified)
    );

    assign sel_mask = {{(N_REF-1){1'b0}}, 1'b1} << ref_sel_q;

    tref_prio #(.N_REF(N_REF), .IDX_W(IDX_W)) u_best (
        .req(qualified), .found(best_found), .idx(best_idx)
    );

    tref_prio #(.N_REF(N_REF), .IDX_W(IDX_W)) u_alt (
        .req(qualified & ~sel_mask), .found(alt_found), .idx(alt_idx)
    );

    tref_jump #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_jump (
        .clk(clk), .rst_n(rst_n), .clr(do_switch), .sample_vld(ts_vld),
        .local_time(local_time), .ref_time(ref_time),
        .thresh(jump_thresh), .jump(jump)
    );

    assign ok_sel = |(ref_ok & sel_mask);
    assign can_sw = (lockout_q == '0);

    // next-state decision
    always_comb begin
        nxt_state   = state_q;
        sw_to       = ref_sel_q;
        do_switch   = 1'b0;
        do_relock   = 1'b0;
        do_lol      = 1'b0;
        do_ho_enter = 1'b0;
        do_ho_exit  = 1'b0;
        do_reacq    = 1'b0;
        unique case (state_q)
            ST_FREE: begin
                if (best_found && can_sw) begin
                    do_switch = 1'b1;
                    sw_to     = best_idx;
                    nxt_state = ST_ACQ;
                end
            end
            ST_ACQ: begin
                if (!ok_sel) begin
                    if (alt_found && can_sw) begin
                        do_switch = 1'b1;
                        sw_to     = alt_idx;
                    end else begin
                        nxt_state = ST_FREE;
                    end
                end else if (pll_lock) begin
                    do_relock = 1'b1;
                    nxt_state = ST_LOCK;
                end else if (best_found && (best_idx < ref_sel_q) && can_sw) begin
                    do_switch = 1'b1;
                    sw_to     = best_idx;
                end
            end
            ST_LOCK: begin
                if (!ok_sel || !pll_lock) begin
                    do_lol = 1'b1;
                    if (alt_found && can_sw) begin
                        do_switch = 1'b1;
                        sw_to     = alt_idx;
                        nxt_state = ST_ACQ;
                    end else begin
                        do_ho_enter = 1'b1;
                        nxt_state   = ST_HOLD;
                    end
                end else if (jump) begin
                    do_reacq  = 1'b1;
                    nxt_state = ST_ACQ;
                end else if (best_found && (best_idx < ref_sel_q) && can_sw) begin
                    do_switch = 1'b1;
                    sw_to     = best_idx;
                    nxt_state = ST_ACQ;
                end
            end
            ST_HOLD: begin
                if (best_found && can_sw) begin
                    do_switch  = 1'b1;
                    do_ho_exit = 1'b1;
                    sw_to      = best_idx;
                    nxt_state  = ST_ACQ;
                end else if (ho_cnt_q == holdover_max) begin
                    do_ho_exit = 1'b1;
                    nxt_state  = ST_FREE;
                end
            end
            default: nxt_state = ST_FREE;
        endcase
    end

    // state register, counters and event strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_FREE;
            ref_sel_q     <= '0;
            lockout_q     <= '0;
            acq_cnt_q     <= '0;
            ho_cnt_q      <= '0;
            ev_switch     <= 1'b0;
            ev_from       <= '0;
            ev_to         <= '0;
            ev_relock     <= 1'b0;
            ev_relock_cyc <= '0;
            ev_lol        <= 1'b0;
            ev_lol_ref    <= '0;
            ev_ho_enter   <= 1'b0;
            ev_ho_exit    <= 1'b0;
            ev_ho_cyc     <= '0;
        end else begin
            state_q     <= nxt_state;
            ref_sel_q   <= sw_to;
            ev_switch   <= do_switch;
            ev_relock   <= do_relock;
            ev_lol      <= do_lol;
            ev_ho_enter <= do_ho_enter;
            ev_ho_exit  <= do_ho_exit;
            if (do_switch) begin
                ev_from   <= ref_sel_q;
                ev_to     <= sw_to;
                lockout_q <= lockout_cycles;
            end else if (lockout_q != '0) begin
                lockout_q <= lockout_q - 1'b1;
            end
            if (do_switch || do_reacq) begin
                acq_cnt_q <= '0;
            end else if (state_q == ST_ACQ && acq_cnt_q != '1) begin
                acq_cnt_q <= acq_cnt_q + 1'b1;
            end
            if (do_relock) ev_relock_cyc <= acq_cnt_q;
            if (do_lol)    ev_lol_ref    <= ref_sel_q;
            if (do_ho_exit) ev_ho_cyc    <= ho_cnt_q;
            if (do_ho_enter) begin
                ho_cnt_q <= '0;
            end else if (state_q == ST_HOLD && ho_cnt_q != '1) begin
                ho_cnt_q <= ho_cnt_q + 1'b1;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        ref_sel = ref_sel_q;
        mode    = state_q;
        ev_jump = jump;
        unique case (state_q)
            ST_LOCK: begin gate = GATE_STRICT;  alarm = 1'b0; end
            ST_HOLD: begin gate = GATE_RELAXED; alarm = 1'b1; end
            ST_ACQ:  begin gate = GATE_MEASURE; alarm = 1'b0; end
            default: begin gate = GATE_MEASURE; alarm = 1'b1; end
        endcase
    end

    assert_switch_after_lockout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_switch |-> ($past(lockout_q) == '0));

    assert_relock_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_relock |-> $past(pll_lock));

    assert_lol_names_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_lol |-> (ev_lol_ref == $past(ref_sel_q)));

    assert_ho_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ho_enter |-> (ev_lol && state_q == ST_HOLD && !ev_switch));

    assert_ho_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FREE && $past(state_q) == ST_HOLD) |-> ($past(ho_cnt_q) == $past(holdover_max)));

    assert_switch_fields_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ev_switch |-> (ev_to == ref_sel_q && ev_from == $past(ref_sel_q)));
endmodule

// File: tb/tref_sel_tb.sv
module tref_sel_tb;
    localparam int N_REF = 4;
    localparam int TIME_W = 32;
    localparam int CNT_W = 16;
    localparam int IDX_W = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N_REF-1:0]  ref_ok;
    logic              pll_lock, ts_vld;
    logic [TIME_W-1:0] local_time, ref_time;
    logic [CNT_W-1:0]  jump_thresh, qual_cycles, lockout_cycles, holdover_max;
    logic [IDX_W-1:0]  ref_sel, ev_from, ev_to, ev_lol_ref;
    logic [1:0]        mode, gate;
    logic              alarm, ev_switch, ev_relock, ev_lol, ev_ho_enter, ev_ho_exit, ev_jump;
    logic [CNT_W-1:0]  ev_relock_cyc, ev_ho_cyc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tref_sel #(.N_REF(N_REF), .TIME_W(TIME_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .pll_lock(pll_lock),
        .ts_vld(ts_vld), .local_time(local_time), .ref_time(ref_time),
        .jump_thresh(jump_thresh), .qual_cycles(qual_cycles),
        .lockout_cycles(lockout_cycles), .holdover_max(holdover_max),
        .ref_sel(ref_sel), .mode(mode), .gate(gate), .alarm(alarm),
        .ev_switch(ev_switch), .ev_from(ev_from), .ev_to(ev_to),
        .ev_relock(ev_relock), .ev_relock_cyc(ev_relock_cyc),
        .ev_lol(ev_lol), .ev_lol_ref(ev_lol_ref),
        .ev_ho_enter(ev_ho_enter), .ev_ho_exit(ev_ho_exit),
        .ev_ho_cyc(ev_ho_cyc), .ev_jump(ev_jump)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ref_ok = '0; pll_lock = 1'b0; ts_vld = 1'b0;
        local_time = '0; ref_time = '0;
        jump_thresh = 16'd10; qual_cycles = '0;
        lockout_cycles = '0; holdover_max = 16'd100;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic sample(input int diff);
        ts_vld = 1'b1;
        ref_time = 32'd5000;
        local_time = 32'd5000 + diff;
        step();
        ts_vld = 1'b0;
    endtask

    function automatic int lowbit(input int p);
        for (int i = 0; i < N_REF; i++) if (p[i]) return i;
        return 0;
    endfunction

    initial begin
        do_reset();
        // R11 reset state
        chk("R11 reset mode", mode, 0);
        chk("R11 reset gate", gate, 2);
        chk("R11 reset alarm", alarm, 1);
        chk("R11 reset sel", ref_sel, 0);
        chk("R11 reset events", {ev_switch, ev_lol, ev_ho_enter, ev_ho_exit, ev_relock}, 0);

        // R1 R12: all health patterns
        for (int p = 0; p < 16; p++) begin
            do_reset();
            ref_ok = 4'(p);
            step();
            chk("R1 mode", mode, (p != 0) ? 1 : 0);
            chk("R1 sel", ref_sel, (p != 0) ? lowbit(p) : 0);
            chk("R12 switch", ev_switch, (p != 0) ? 1 : 0);
            if (p != 0) chk("R12 to", ev_to, lowbit(p));
        end

        // R1 preemption in ACQUIRE
        do_reset();
        ref_ok = 4'b1000; step();
        ref_ok = 4'b1010; step();
        chk("R1 preempt sel", ref_sel, 1);
        chk("R12 preempt from", ev_from, 3);

        // R2 qualification sweep
        for (int q = 0; q < 6; q++) begin
            do_reset();
            qual_cycles = 16'(q);
            ref_ok = 4'b0001;
            for (int k = 0; k < q; k++) step();
            chk("R2 not yet", mode, 0);
            step();
            chk("R2 qualified", mode, 1);
        end
        do_reset();
        qual_cycles = 16'd3;
        ref_ok = 4'b0001; step(); step();
        ref_ok = 4'b0000; step();
        ref_ok = 4'b0001; step(); step(); step();
        chk("R2 restart", mode, 0);
        step();
        chk("R2 restart done", mode, 1);

        // R3 lockout
        do_reset();
        lockout_cycles = 16'd5;
        pll_lock = 1'b1;
        ref_ok = 4'b0010; step();
        ref_ok = 4'b0011;
        begin
            int n = 0;
            for (int k = 0; k < 20; k++) begin
                step(); n++;
                if (ev_switch) break;
            end
            chk("R3 lockout edges", n, 6);
            chk("R3 sel", ref_sel, 0);
        end

        // R4 relock timing
        do_reset();
        ref_ok = 4'b0001; step();
        for (int k = 0; k < 4; k++) step();
        pll_lock = 1'b1; step();
        chk("R4 relock", ev_relock, 1);
        chk("R4 relock cyc", ev_relock_cyc, 4);
        chk("R11 locked mode", mode, 2);
        chk("R11 locked gate", gate, 0);
        chk("R11 locked alarm", alarm, 0);

        // R5 R12 failover to alternate
        do_reset();
        pll_lock = 1'b1; ref_ok = 4'b0011; step(); step();
        ref_ok = 4'b0010; step();
        chk("R5 lol", ev_lol, 1);
        chk("R5 lol ref", ev_lol_ref, 0);
        chk("R12 fail switch", ev_switch, 1);
        chk("R12 fail from", ev_from, 0);
        chk("R12 fail to", ev_to, 1);
        chk("R6 no holdover", ev_ho_enter, 0);
        chk("R5 mode", mode, 1);

        // R6 R8 holdover and timeout
        do_reset();
        holdover_max = 16'd6;
        pll_lock = 1'b1; ref_ok = 4'b0001; step(); step();
        ref_ok = 4'b0000; step();
        chk("R6 lol", ev_lol, 1);
        chk("R6 enter", ev_ho_enter, 1);
        chk("R11 hold mode", mode, 3);
        chk("R11 hold gate", gate, 1);
        chk("R11 hold alarm", alarm, 1);
        for (int k = 0; k < 6; k++) step();
        chk("R8 still hold", mode, 3);
        step();
        chk("R8 free", mode, 0);
        chk("R8 exit", ev_ho_exit, 1);
        chk("R8 dur", ev_ho_cyc, 6);

        // R7 holdover exit with switch in same cycle
        do_reset();
        pll_lock = 1'b1; ref_ok = 4'b0001; step(); step();
        ref_ok = 4'b0000; step();
        step(); step(); step();
        ref_ok = 4'b0100; step();
        chk("R7 switch", ev_switch, 1);
        chk("R7 exit", ev_ho_exit, 1);
        chk("R7 dur", ev_ho_cyc, 3);
        chk("R7 from", ev_from, 0);
        chk("R7 to", ev_to, 2);
        chk("R7 mode", mode, 1);

        // R9 jump threshold sweep
        do_reset();
        sample(1000);
        chk("R9 first sample", ev_jump, 0);
        for (int d = -13; d <= 13; d++) begin
            sample(1000);
            sample(1000 + d);
            chk("R9 jump", ev_jump, (d > 10 || d < -10) ? 1 : 0);
        end
        step();
        chk("R9 idle", ev_jump, 0);

        // R10 jump while locked
        do_reset();
        pll_lock = 1'b1; ref_ok = 4'b0001; step(); step();
        sample(0);
        sample(50);
        chk("R10 jump", ev_jump, 1);
        chk("R10 still locked", mode, 2);
        step();
        chk("R10 reacq", mode, 1);
        chk("R10 gate", gate, 2);
        chk("R10 no lol", ev_lol, 0);
        chk("R10 no switch", ev_switch, 0);
        step();
        chk("R10 relock", ev_relock, 1);
        chk("R10 relock cyc", ev_relock_cyc, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule